// File: doc/BRIEF.md
# Polled Handshake I/O Port

This block is the device side of a simple I/O port that a host operates purely by polling. The host sees four byte-wide registers on a small address bus: a status word it polls, a control word that carries a command code and a go flag, a receive register filled by the device, and a transmit register it loads before a command. Behind the registers sits a byte-wide device link with a valid/ready pair in each direction.

The host places a byte in the transmit register, writes the command code together with the go flag (command-ready), and then polls status until busy clears. A controller state machine enforces the handshake in hardware. It notices command-ready and raises busy. It moves one byte over the device link, or flags an error for an unknown code. It then drops command-ready and settles the error bit, and only then drops busy. One command is in flight at a time. The host cannot disturb a command once busy is set.

The controller states are IDLE (waiting for command-ready), CLAIM (busy raised, command decoded), SEND (offering the transmit byte to the device), RECV (waiting for a device byte), DONE (clearing command-ready and error after a good transfer), FAULT (setting error and clearing command-ready), and RELEASE (clearing busy). The transitions are as follows. IDLE goes to CLAIM when command-ready is set. CLAIM goes to SEND for a write code, to RECV for a read code, and to FAULT for any other code. SEND goes to DONE when the device accepts the byte. RECV goes to DONE when the device offers a byte. DONE and FAULT both go to RELEASE. RELEASE goes to IDLE.

Top module: `pio_port`

## Requirements
- R1: After reset the status and control registers read 0, and neither device strobe (dev_out_valid, dev_in_ready) is active.
- R2: The address decode is 0 = status, 1 = control, 2 = data-in, 3 = data-out. Status bit 0 is busy, bit 1 is error and bit 2 is data-available. Control bit 0 is command-ready and bits 2:1 are the command code. All other read bits are 0.
- R3: Command code 01 (write) presents the data-out byte on dev_out_data with dev_out_valid, and holds both stable until dev_out_ready is seen. Exactly one byte is transferred per command.
- R4: Busy rises in the cycle after the controller sees command-ready. The device link is driven only while busy is set.
- R5: Command code 10 (read) waits for dev_in_valid, stores dev_in_data in data-in and sets data-available. A host read of address 2 clears data-available.
- R6: A command ends by clearing command-ready and setting or clearing error, and then clears busy one cycle later. A successful command clears an error left by an earlier command.
- R7: While busy is set, host writes to control and data-out are ignored.
- R8: Command codes 00 and 11 set error, clear command-ready and then busy, and cause no device transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Register select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (clears data-available on address 2) |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Register read data, combinational from host_addr |
| dev_out_data | output | DATA_W | Byte toward the device |
| dev_out_valid | output | 1 | Outgoing byte offered |
| dev_out_ready | input | 1 | Device accepts outgoing byte |
| dev_in_data | input | DATA_W | Byte from the device |
| dev_in_valid | input | 1 | Device offers a byte |
| dev_in_ready | output | 1 | Port waits for an incoming byte |

## Verification
Some properties are checked on every clock cycle. The device strobes appear only under busy. An offered outgoing byte stays put while stalled. Busy rises only after command-ready, and command-ready is already low when busy falls. Writes during busy leave the command and transmit byte untouched. A device strobe always matches the command code, and data-available clears on a read of data-in. Other behaviour only the bench scenarios can show: the exact bytes that reach the device or data-in, the register values the host sees after each kind of command, the recovery of error by a later good command, and the absence of any transfer for a bad code.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int ADDR_W = 2;
    localparam int CMD_W  = 2;

    localparam logic [ADDR_W-1:0] REG_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] REG_CTRL   = 2'd1;
    localparam logic [ADDR_W-1:0] REG_DIN    = 2'd2;
    localparam logic [ADDR_W-1:0] REG_DOUT   = 2'd3;

    localparam logic [CMD_W-1:0] OP_WRITE = 2'b01;
    localparam logic [CMD_W-1:0] OP_READ  = 2'b10;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CLAIM,
        S_SEND,
        S_RECV,
        S_DONE,
        S_FAULT,
        S_RELEASE
    } pio_state_e;

endpackage

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              busy,
    input  logic              err,
    input  logic              clr_rdy,
    input  logic              din_load,
    input  logic [DATA_W-1:0] din_byte,
    output logic              cmd_rdy,
    output logic [CMD_W-1:0]  cmd_code,
    output logic [DATA_W-1:0] dout_q,
    output logic              avail
);

    localparam int PAD_W = DATA_W - 3;

    logic [DATA_W-1:0] din_q;
    logic              wr_ctrl;
    logic              wr_dout;
    logic              rd_din;

    // Host writes only land while the controller is idle
    assign wr_ctrl = host_wr && !busy && (host_addr == REG_CTRL);
    assign wr_dout = host_wr && !busy && (host_addr == REG_DOUT);
    assign rd_din  = host_rd && (host_addr == REG_DIN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_rdy  <= 1'b0;
            cmd_code <= '0;
        end else if (clr_rdy) begin
            cmd_rdy  <= 1'b0;
        end else if (wr_ctrl) begin
            cmd_rdy  <= host_wdata[0];
            cmd_code <= host_wdata[CMD_W:1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (wr_dout) begin
            dout_q <= host_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q <= '0;
            avail <= 1'b0;
        end else if (din_load) begin
            din_q <= din_byte;
            avail <= 1'b1;
        end else if (rd_din) begin
            avail <= 1'b0;
        end
    end

    always_comb begin
        unique case (host_addr)
            REG_STATUS: host_rdata = {{PAD_W{1'b0}}, avail, err, busy};
            REG_CTRL:   host_rdata = {{PAD_W{1'b0}}, cmd_code, cmd_rdy};
            REG_DIN:    host_rdata = din_q;
            REG_DOUT:   host_rdata = dout_q;
            default:    host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pio_fsm.sv
module pio_fsm
    import pio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_rdy,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic [DATA_W-1:0] dout_q,
    output logic              busy,
    output logic              err,
    output logic              clr_rdy,
    output logic              din_load,
    output logic [DATA_W-1:0] din_byte,
    output logic [DATA_W-1:0] dev_out_data,
    output logic              dev_out_valid,
    input  logic              dev_out_ready,
    input  logic [DATA_W-1:0] dev_in_data,
    input  logic              dev_in_valid,
    output logic              dev_in_ready
);

    pio_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Error flag: settled in DONE or FAULT, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)                  err <= 1'b0;
        else if (state_q == S_DONE)  err <= 1'b0;
        else if (state_q == S_FAULT) err <= 1'b1;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (cmd_rdy) state_d = S_CLAIM;
            S_CLAIM: begin
                if (cmd_code == OP_WRITE)     state_d = S_SEND;
                else if (cmd_code == OP_READ) state_d = S_RECV;
                else                          state_d = S_FAULT;
            end
            S_SEND:    if (dev_out_ready) state_d = S_DONE;
            S_RECV:    if (dev_in_valid)  state_d = S_DONE;
            S_DONE:    state_d = S_RELEASE;
            S_FAULT:   state_d = S_RELEASE;
            S_RELEASE: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Outputs decoded from the current state
    always_comb begin
        busy          = 1'b1;
        clr_rdy       = 1'b0;
        din_load      = 1'b0;
        dev_out_valid = 1'b0;
        dev_in_ready  = 1'b0;
        unique case (state_q)
            S_IDLE:    busy = 1'b0;
            S_CLAIM:   ;
            S_SEND:    dev_out_valid = 1'b1;
            S_RECV: begin
                dev_in_ready = 1'b1;
                din_load     = dev_in_valid;
            end
            S_DONE:    clr_rdy = 1'b1;
            S_FAULT:   clr_rdy = 1'b1;
            S_RELEASE: ;
            default:   busy = 1'b0;
        endcase
    end

    assign dev_out_data = dout_q;
    assign din_byte     = dev_in_data;

endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [DATA_W-1:0] dev_out_data,
    output logic              dev_out_valid,
    input  logic              dev_out_ready,
    input  logic [DATA_W-1:0] dev_in_data,
    input  logic              dev_in_valid,
    output logic              dev_in_ready
);

    logic              busy;
    logic              err;
    logic              clr_rdy;
    logic              din_load;
    logic [DATA_W-1:0] din_byte;
    logic              cmd_rdy;
    logic [CMD_W-1:0]  cmd_code;
    logic [DATA_W-1:0] dout_q;
    logic              avail;

    pio_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .err        (err),
        .clr_rdy    (clr_rdy),
        .din_load   (din_load),
        .din_byte   (din_byte),
        .cmd_rdy    (cmd_rdy),
        .cmd_code   (cmd_code),
        .dout_q     (dout_q),
        .avail      (avail)
    );

    pio_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_rdy       (cmd_rdy),
        .cmd_code      (cmd_code),
        .dout_q        (dout_q),
        .busy          (busy),
        .err           (err),
        .clr_rdy       (clr_rdy),
        .din_load      (din_load),
        .din_byte      (din_byte),
        .dev_out_data  (dev_out_data),
        .dev_out_valid (dev_out_valid),
        .dev_out_ready (dev_out_ready),
        .dev_in_data   (dev_in_data),
        .dev_in_valid  (dev_in_valid),
        .dev_in_ready  (dev_in_ready)
    );

endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk
    import pio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic              host_rd,
    input logic [DATA_W-1:0] dev_out_data,
    input logic              dev_out_valid,
    input logic              dev_out_ready,
    input logic              dev_in_ready,
    input logic              busy,
    input logic              cmd_rdy,
    input logic [CMD_W-1:0]  cmd_code,
    input logic [DATA_W-1:0] dout_q,
    input logic              avail,
    input logic              din_load
);

    logic wr_ctrl, wr_dout, rd_din;
    assign wr_ctrl = host_wr && (host_addr == REG_CTRL);
    assign wr_dout = host_wr && (host_addr == REG_DOUT);
    assign rd_din  = host_rd && (host_addr == REG_DIN);

    p_out_under_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_out_valid |-> busy);

    p_in_under_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_in_ready |-> busy);

    p_busy_follows_rdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_rdy));

    p_out_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dev_out_valid && !dev_out_ready |=> dev_out_valid && $stable(dev_out_data));

    p_rdy_low_at_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !cmd_rdy);

    p_rdy_clears_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_rdy) && !$past(wr_ctrl) |-> busy);

    p_ctrl_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_ctrl |=> $stable(cmd_code));

    p_dout_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_dout |=> $stable(dout_q));

    p_send_only_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dev_out_valid |-> cmd_code == OP_WRITE);

    p_recv_only_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dev_in_ready |-> cmd_code == OP_READ);

    p_avail_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_din && !din_load |=> !avail);

endmodule

bind pio_port pio_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_addr     (host_addr),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .dev_out_data  (dev_out_data),
    .dev_out_valid (dev_out_valid),
    .dev_out_ready (dev_out_ready),
    .dev_in_ready  (dev_in_ready),
    .busy          (busy),
    .cmd_rdy       (cmd_rdy),
    .cmd_code      (cmd_code),
    .dout_q        (dout_q),
    .avail         (avail),
    .din_load      (din_load)
);

// File: tb/pio_port_bench.sv
module pio_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    host_addr = '0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic [DW-1:0] dev_out_data;
    logic          dev_out_valid;
    logic          dev_out_ready = 1'b1;
    logic [DW-1:0] dev_in_data = '0;
    logic          dev_in_valid = 1'b0;
    logic          dev_in_ready;

    int            n_checks = 0;
    int            n_errors = 0;
    logic [DW-1:0] exp_q[$];
    int            n_sent = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_port #(.DATA_W(DW)) u_pio_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_addr     (host_addr),
        .host_wr       (host_wr),
        .host_rd       (host_rd),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .dev_out_data  (dev_out_data),
        .dev_out_valid (dev_out_valid),
        .dev_out_ready (dev_out_ready),
        .dev_in_data   (dev_in_data),
        .dev_in_valid  (dev_in_valid),
        .dev_in_ready  (dev_in_ready)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [DW-1:0] s;
        for (int i = 0; i < 100; i++) begin
            host_read(2'd0, s);
            if (!s[0]) break;
        end
    endtask

    // Driver: queues the expected device byte and issues a write command
    task automatic send_cmd(input logic [DW-1:0] b);
        exp_q.push_back(b);
        host_write(2'd3, b);
        host_write(2'd1, 8'h03);
    endtask

    // Monitor: scoreboard of bytes leaving on the device link
    always begin
        @(negedge clk);
        #1;
        if (rst_n && dev_out_valid && dev_out_ready) begin
            n_sent++;
            if (exp_q.size() == 0) begin
                n_checks++; n_errors++;
                $display("FAIL R8: actual=%h expected=no transfer", dev_out_data);
            end else begin
                check("R3 device byte", dev_out_data, exp_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] r;
        int sent_before;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 strobes", {6'd0, dev_out_valid, dev_in_ready}, 8'h00);
        rst_n = 1'b1;
        host_read(2'd0, r); check("R1 status", r, 8'h00);
        host_read(2'd1, r); check("R1 control", r, 8'h00);

        // R3/R6: plain write command
        send_cmd(8'hC3);
        wait_idle();
        host_read(2'd0, r); check("R6 status after write", r, 8'h00);
        host_read(2'd1, r); check("R6 control after write", r, 8'h02);
        host_read(2'd3, r); check("R2 data-out readback", r, 8'hC3);

        // R7/R4: stalled write, host writes while busy must be ignored
        dev_out_ready = 1'b0;
        send_cmd(8'hA5);
        repeat (3) @(negedge clk);
        host_read(2'd0, r); check("R4 busy while stalled", r, 8'h01);
        host_write(2'd3, 8'h5A);
        host_write(2'd1, 8'h05);
        host_read(2'd1, r); check("R7 control locked", r, 8'h03);
        host_read(2'd3, r); check("R7 data-out locked", r, 8'hA5);
        dev_out_ready = 1'b1;
        wait_idle();
        host_read(2'd1, r); check("R6 rdy cleared", r, 8'h02);

        // R5: read command with a late device byte
        host_write(2'd1, 8'h05);
        repeat (4) @(negedge clk);
        host_read(2'd0, r); check("R5 waiting busy", r, 8'h01);
        dev_in_data = 8'h3C; dev_in_valid = 1'b1;
        wait_idle();
        dev_in_valid = 1'b0;
        host_read(2'd0, r); check("R5 data-available", r, 8'h04);
        host_read(2'd2, r); check("R5 data-in byte", r, 8'h3C);
        host_read(2'd0, r); check("R5 avail cleared", r, 8'h00);

        // R5: read with byte already waiting
        dev_in_data = 8'h81; dev_in_valid = 1'b1;
        host_write(2'd1, 8'h05);
        wait_idle();
        dev_in_valid = 1'b0;
        host_read(2'd2, r); check("R5 second byte", r, 8'h81);

        // R8: unsupported codes 11 and 00
        sent_before = n_sent;
        host_write(2'd3, 8'hEE);
        host_write(2'd1, 8'h07);
        wait_idle();
        host_read(2'd0, r); check("R8 error after code 11", r, 8'h02);
        host_read(2'd1, r); check("R8 rdy cleared code 11", r, 8'h06);
        host_write(2'd1, 8'h01);
        wait_idle();
        host_read(2'd0, r); check("R8 error after code 00", r, 8'h02);
        host_read(2'd1, r); check("R8 rdy cleared code 00", r, 8'h00);
        check("R8 no transfer", n_sent[7:0], sent_before[7:0]);

        // R6: a good command clears the error
        send_cmd(8'h17);
        wait_idle();
        host_read(2'd0, r); check("R6 error cleared", r, 8'h00);

        repeat (3) @(negedge clk);
        check("R3 queue drained", 8'(exp_q.size()), 8'h00);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule